// File: doc/BRIEF.md
# Video Processor Control Port Decoder

This block sits behind the 16-bit control port of a tile-based video display processor. Each control word is sorted into one of three kinds. A register write carries an index and an 8-bit value. The first half of an access command carries two code bits and the low fourteen address bits. The second half carries the upper two address bits, the upper two code bits and a DMA request.

The block holds the current access code and address, and the other side of the processor uses them for every data port transfer. After each data port read or write, the address advances by the auto-increment value. The decoder keeps its own copy of the two registers it needs: the auto-increment register and the mode register that holds the DMA enable. Every register write is also passed out as a strobe with its index and value, so the full register file can live elsewhere. A DMA request that the mode register allows sets a busy flag. The flag shows in the status word until the DMA engine reports that it has finished.

Top module: `vid_ctrl_port`

## Requirements
- R1: After reset the access code and address are 0, no second word is pending, the auto-increment is 0, the DMA enable is off, DMA is idle and the register strobe is low.
- R2: A control word with bits 15:14 = 2'b10, written while no second word is pending, is a register write. If its index (bits 12:8) is below 24 (0x18), reg_we_o is high for one cycle after the write, with the index on reg_idx_o and bits 7:0 on reg_val_o. An index of 24 or more gives no strobe and changes nothing. A register write never changes the code or the address.
- R3: Any other control word written while nothing is pending is a first word. Its bits 15:14 go to code bits 1:0 and its bits 13:0 go to address bits 13:0. Address bits 15:14 and code bits 3:2 keep their values, and a second word becomes pending.
- R4: A control word written while a second word is pending is always taken as the second word, whatever its top bits. Its bits 1:0 go to address bits 15:14 and its bits 5:4 go to code bits 3:2. The pending flag clears and no register strobe is issued.
- R5: A data port access adds the value of register 15 (0x0F) to the address, wrapping modulo 2^16. If a control write arrives in the same cycle, the control write wins and the access has no effect on the address.
- R6: auto_inc_o always shows the value last written to register 15.
- R7: A second word with bit 7 set starts a DMA operation only if bit 4 (0x10) of register 1 is set.
- R8: status_o bit 1 is 1 while DMA is busy, and every other bit of status_o is 0. dma_done_i clears the busy flag unless a new DMA starts in the same cycle.
- R9: A first and second word together give these codes: VRAM write 4'b0001, CRAM write 4'b0011, VSRAM write 4'b0101, VRAM read 4'b0000, VSRAM read 4'b0100, CRAM read 4'b1000.
- R10: A data port access clears a pending second word, so the next control word with top bits 2'b10 is treated as a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control port write strobe |
| ctrl_wdata_i | input | 16 | Control word |
| data_acc_i | input | 1 | Data port read or write done this cycle |
| dma_done_i | input | 1 | DMA engine has finished |
| reg_we_o | output | 1 | Register write strobe |
| reg_idx_o | output | 5 | Index of the register being written |
| reg_val_o | output | 8 | Value of the register being written |
| acc_code_o | output | 4 | Current access code |
| acc_addr_o | output | 16 | Current access address |
| auto_inc_o | output | 8 | Auto-increment value |
| dma_req_o | output | 1 | DMA busy, request to the engine |
| status_o | output | 16 | Status word, bit 1 = DMA busy |

## Verification
Every output comes from a register, so each result appears one clock edge after the write, access or done pulse that causes it. status_o follows the DMA busy register with no further delay. The bench changes its inputs on the falling edge and reads the outputs at the next falling edge. That is exactly one rising edge later, which is the only cycle in which the one-cycle register strobe can be seen. One extra falling edge is then used to confirm that the strobe has dropped again.

// File: rtl/vid_ctrl_pkg.sv
package vid_ctrl_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 16;
  localparam int CODE_W = 4;
  localparam int REG_W  = 8;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    WK_NONE   = 2'd0,
    WK_REG    = 2'd1,
    WK_FIRST  = 2'd2,
    WK_SECOND = 2'd3
  } word_kind_e;
endpackage

// File: rtl/vid_ctrl_decode.sv
module vid_ctrl_decode
  import vid_ctrl_pkg::*;
#(
  parameter int NUM_REGS = 24
) (
  input  logic              we_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              pend_i,
  output word_kind_e        kind_o,
  output logic              reg_hit_o
);
  always_comb begin
    kind_o = WK_NONE;
    if (we_i) begin
      if (pend_i)                     kind_o = WK_SECOND;
      else if (word_i[15:14] == 2'b10) kind_o = WK_REG;
      else                            kind_o = WK_FIRST;
    end
  end

  assign reg_hit_o = (kind_o == WK_REG) && (int'(word_i[12:8]) < NUM_REGS);
endmodule

// File: rtl/vid_ctrl_regs.sv
module vid_ctrl_regs
  import vid_ctrl_pkg::*;
#(
  parameter int INC_REG    = 15,
  parameter int MODE_REG   = 1,
  parameter int DMA_EN_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [REG_W-1:0]  val_i,
  output logic              reg_we_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [REG_W-1:0]  reg_val_o,
  output logic [REG_W-1:0]  auto_inc_o,
  output logic              dma_en_o
);
  localparam int NKEEP = 2;
  localparam int KEEP_IDX [NKEEP] = '{INC_REG, MODE_REG};

  logic [REG_W-1:0] keep_q [NKEEP];

  for (genvar g = 0; g < NKEEP; g++) begin : g_keep
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       keep_q[g] <= '0;
      else if (hit_i && (int'(idx_i) == KEEP_IDX[g]))    keep_q[g] <= val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_we_o  <= 1'b0;
      reg_idx_o <= '0;
      reg_val_o <= '0;
    end else begin
      reg_we_o <= hit_i;
      if (hit_i) begin
        reg_idx_o <= idx_i;
        reg_val_o <= val_i;
      end
    end
  end

  assign auto_inc_o = keep_q[0];
  assign dma_en_o   = keep_q[1][DMA_EN_BIT];
endmodule

// File: rtl/vid_ctrl_cmd.sv
module vid_ctrl_cmd
  import vid_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  word_kind_e        kind_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              data_acc_i,
  input  logic [REG_W-1:0]  inc_i,
  output logic              pend_o,
  output logic [CODE_W-1:0] code_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LO_W = ADDR_W - 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      code_o <= '0;
      addr_o <= '0;
    end else begin
      unique case (kind_i)
        WK_FIRST: begin
          code_o[1:0]      <= word_i[15:14];
          addr_o[LO_W-1:0] <= word_i[LO_W-1:0];
          pend_o           <= 1'b1;
        end
        WK_SECOND: begin
          addr_o[ADDR_W-1:LO_W] <= word_i[1:0];
          code_o[3:2]           <= word_i[5:4];
          pend_o                <= 1'b0;
        end
        WK_REG: ;
        default: begin
          // control write takes priority over a data access
          if (data_acc_i) begin
            addr_o <= addr_o + ADDR_W'(inc_i);
            pend_o <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vid_ctrl_dma.sv
module vid_ctrl_dma
  import vid_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic busy_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_o <= 1'b0;
    else if (start_i) busy_o <= 1'b1;
    else if (done_i)  busy_o <= 1'b0;
  end
endmodule

// File: rtl/vid_ctrl_port.sv
module vid_ctrl_port
  import vid_ctrl_pkg::*;
#(
  parameter int NUM_REGS   = 24,
  parameter int INC_REG    = 15,
  parameter int MODE_REG   = 1,
  parameter int DMA_EN_BIT = 4,
  parameter int DMA_REQ_BIT = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [15:0] ctrl_wdata_i,
  input  logic        data_acc_i,
  input  logic        dma_done_i,
  output logic        reg_we_o,
  output logic [4:0]  reg_idx_o,
  output logic [7:0]  reg_val_o,
  output logic [3:0]  acc_code_o,
  output logic [15:0] acc_addr_o,
  output logic [7:0]  auto_inc_o,
  output logic        dma_req_o,
  output logic [15:0] status_o
);
  word_kind_e kind;
  logic       reg_hit;
  logic       pend;
  logic       dma_en;
  logic       dma_start;

  vid_ctrl_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .we_i      (ctrl_we_i),
    .word_i    (ctrl_wdata_i),
    .pend_i    (pend),
    .kind_o    (kind),
    .reg_hit_o (reg_hit)
  );

  vid_ctrl_regs #(
    .INC_REG    (INC_REG),
    .MODE_REG   (MODE_REG),
    .DMA_EN_BIT (DMA_EN_BIT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (reg_hit),
    .idx_i      (ctrl_wdata_i[12:8]),
    .val_i      (ctrl_wdata_i[7:0]),
    .reg_we_o   (reg_we_o),
    .reg_idx_o  (reg_idx_o),
    .reg_val_o  (reg_val_o),
    .auto_inc_o (auto_inc_o),
    .dma_en_o   (dma_en)
  );

  vid_ctrl_cmd u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .word_i     (ctrl_wdata_i),
    .data_acc_i (data_acc_i),
    .inc_i      (auto_inc_o),
    .pend_o     (pend),
    .code_o     (acc_code_o),
    .addr_o     (acc_addr_o)
  );

  assign dma_start = (kind == WK_SECOND) && ctrl_wdata_i[DMA_REQ_BIT] && dma_en;

  vid_ctrl_dma u_dma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dma_start),
    .done_i  (dma_done_i),
    .busy_o  (dma_req_o)
  );

  assign status_o = {14'b0, dma_req_o, 1'b0};
endmodule

// File: rtl/vid_ctrl_port_chk.sv
module vid_ctrl_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_we_i,
  input logic [15:0] ctrl_wdata_i,
  input logic        data_acc_i,
  input logic        dma_done_i,
  input logic        reg_we_o,
  input logic [15:0] acc_addr_o,
  input logic [7:0]  auto_inc_o,
  input logic        dma_req_o,
  input logic [15:0] status_o,
  input logic        dma_en
);
  a_r2_strobe_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ($past(ctrl_we_i) && ($past(ctrl_wdata_i[15:14]) == 2'b10)));

  a_r5_addr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && !ctrl_we_i) |=> (acc_addr_o == $past(acc_addr_o) + 16'($past(auto_inc_o))));

  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!data_acc_i && !ctrl_we_i) |=> $stable(acc_addr_o));

  a_r7_dma_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> ($past(ctrl_we_i) && $past(ctrl_wdata_i[7]) && $past(dma_en)));

  a_r8_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_done_i && !ctrl_we_i) |=> !status_o[1]);
endmodule

bind vid_ctrl_port vid_ctrl_port_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .data_acc_i   (data_acc_i),
  .dma_done_i   (dma_done_i),
  .reg_we_o     (reg_we_o),
  .acc_addr_o   (acc_addr_o),
  .auto_inc_o   (auto_inc_o),
  .dma_req_o    (dma_req_o),
  .status_o     (status_o),
  .dma_en       (dma_en)
);

// File: tb/vid_ctrl_port_bench.sv
module vid_ctrl_port_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [15:0] ctrl_wdata_i = '0;
  logic        data_acc_i = 1'b0;
  logic        dma_done_i = 1'b0;
  logic        reg_we_o;
  logic [4:0]  reg_idx_o;
  logic [7:0]  reg_val_o;
  logic [3:0]  acc_code_o;
  logic [15:0] acc_addr_o;
  logic [7:0]  auto_inc_o;
  logic        dma_req_o;
  logic [15:0] status_o;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #10 clk_i = ~clk_i;

  vid_ctrl_port u_vid_ctrl_port (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one control word for one cycle; returns at the next falling edge
  task automatic cwr(input logic [15:0] w);
    ctrl_we_i = 1'b1; ctrl_wdata_i = w;
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic cmd(input logic [15:0] w1, input logic [15:0] w2);
    cwr(w1); cwr(w2);
  endtask

  task automatic dacc();
    data_acc_i = 1'b1;
    @(negedge clk_i);
    data_acc_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 code", 32'(acc_code_o), 0);
    chk("R1 addr", 32'(acc_addr_o), 0);
    chk("R1 inc", 32'(auto_inc_o), 0);
    chk("R1 dma", 32'(dma_req_o), 0);
    chk("R1 status", 32'(status_o), 0);
    chk("R1 strobe", 32'(reg_we_o), 0);
  endtask

  task automatic t_reg_write();
    cwr(16'h8F02);
    chk("R2 strobe", 32'(reg_we_o), 1);
    chk("R2 idx", 32'(reg_idx_o), 32'h0F);
    chk("R2 val", 32'(reg_val_o), 32'h02);
    @(negedge clk_i);
    chk("R2 strobe drops", 32'(reg_we_o), 0);
    chk("R6 inc", 32'(auto_inc_o), 2);
    chk("R2 addr kept", 32'(acc_addr_o), 0);
    cwr(16'h9855);
    chk("R2 idx 0x18 no strobe", 32'(reg_we_o), 0);
    chk("R2 idx 0x18 no change", 32'(auto_inc_o), 2);
  endtask

  task automatic t_codes();
    cmd(16'h4000, 16'h0000); chk("R9 vram write", 32'(acc_code_o), 4'b0001);
    cmd(16'hC000, 16'h0000); chk("R9 cram write", 32'(acc_code_o), 4'b0011);
    cmd(16'h4000, 16'h0010); chk("R9 vsram write", 32'(acc_code_o), 4'b0101);
    cmd(16'h0000, 16'h0000); chk("R9 vram read", 32'(acc_code_o), 4'b0000);
    cmd(16'h0000, 16'h0010); chk("R9 vsram read", 32'(acc_code_o), 4'b0100);
    cmd(16'h0000, 16'h0020); chk("R9 cram read", 32'(acc_code_o), 4'b1000);
  endtask

  task automatic t_split();
    cmd(16'h4000, 16'h0013);
    chk("R4 addr hi", 32'(acc_addr_o), 32'hC000);
    chk("R4 code hi", 32'(acc_code_o), 4'b0101);
    cwr(16'h4123);
    chk("R3 addr merge", 32'(acc_addr_o), 32'hC123);
    chk("R3 code merge", 32'(acc_code_o), 4'b0101);
    cwr(16'h8001); // pending: taken as second word
    chk("R4 no strobe", 32'(reg_we_o), 0);
    chk("R4 addr", 32'(acc_addr_o), 32'h4123);
    chk("R4 code", 32'(acc_code_o), 4'b0001);
    chk("R4 inc kept", 32'(auto_inc_o), 2);
  endtask

  task automatic t_advance();
    cmd(16'h7FFF, 16'h0003);
    chk("R5 setup", 32'(acc_addr_o), 32'hFFFF);
    dacc();
    chk("R5 wrap", 32'(acc_addr_o), 32'h0001);
    cwr(16'h8F10);
    dacc();
    chk("R5 inc 0x10", 32'(acc_addr_o), 32'h0011);
    ctrl_we_i = 1'b1; ctrl_wdata_i = 16'h8F02; data_acc_i = 1'b1;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; data_acc_i = 1'b0;
    chk("R5 ctrl wins", 32'(acc_addr_o), 32'h0011);
    chk("R6 inc updated", 32'(auto_inc_o), 2);
  endtask

  task automatic t_pend_clear();
    cwr(16'h4000);
    dacc();
    chk("R10 addr", 32'(acc_addr_o), 32'h0002);
    cwr(16'h8F07);
    chk("R10 reg strobe", 32'(reg_we_o), 1);
    @(negedge clk_i);
    chk("R10 inc", 32'(auto_inc_o), 7);
  endtask

  task automatic t_dma();
    cwr(16'h8100);
    cmd(16'h4000, 16'h0080);
    chk("R7 disabled", 32'(status_o), 0);
    cwr(16'h8110);
    cmd(16'h4000, 16'h0080);
    chk("R8 status busy", 32'(status_o), 32'h0002);
    chk("R7 req", 32'(dma_req_o), 1);
    dma_done_i = 1'b1;
    @(negedge clk_i);
    dma_done_i = 1'b0;
    chk("R8 done clears", 32'(status_o), 0);
    cmd(16'h4000, 16'h0000);
    chk("R7 no bit7", 32'(dma_req_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reg_write();
    t_codes();
    t_split();
    t_advance();
    t_pend_clear();
    t_dma();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(negedge clk_i);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule